// File: doc/BRIEF.md
# Resettable 1:2 Sample Demultiplexer

This block accepts one sample on every edge of a fast sample clock and deals the stream out onto two half-rate ports. On each port update the auxiliary port receives the older sample of a pair and the primary port the newer one. A registered half-rate flag, `rdyOut`, toggles in the sample-clock domain. Its 0-to-1 transitions mark the edges on which both ports take new values.

A synchronous realignment input, `syncIn`, is delayed and sent out again as `rstOut`. Several demultiplexers can be chained this way: a downstream stage sees the pulse ahead of the data it frames, and `rdyOut` keeps toggling while the pulse is high. When `rstOut` returns low, the half-rate flag is forced to a reference phase.

- If the flag is already in that phase, nothing is interrupted.
- If it is not, one fast cycle is swallowed, and the pairing of samples on the ports moves by one sample.

Latencies are counted in whole sample-clock edges. `rstN` is the asynchronous power-on reset.

Top module: `sample_demux_1to2`

## Requirements
- R1: While `rstN` is low, `priPort`, `auxPort`, `rdyOut` and `rstOut` are all 0.
- R2: While `rstOut` is 0, `rdyOut` inverts on every sample-clock edge.
- R3: `priPort` and `auxPort` hold their values on every edge except one where `rdyOut` goes from 0 to 1.
- R4: On each port update, `auxPort` takes the sample presented PRI_LAT+1 (default 8) edges earlier. That is exactly one edge older than the sample that `priPort` takes.
- R5: On each port update, `priPort` takes the sample presented PRI_LAT (default 7) edges before that update edge. Edges are counted from the first edge after `rstN` rises, and samples from before that edge read as 0.
- R6: `rstOut` equals `syncIn` delayed by PRI_LAT-1 (default 6) edges, so every pulse keeps its length.
- R7: While `rstOut` is 1 across an edge, `rdyOut` still inverts on that edge.
- R8: On the edge where `rstOut` goes from 1 to 0, `rdyOut` becomes 0. If it was 1, this is an ordinary toggle. If it was 0, it stays 0 for one extra cycle (a swallowed cycle).
- R9: The first port update after `rstOut` falls happens on the next edge. `auxPort` then receives the sample presented on the same edge as the last high `syncIn`, and `priPort` receives the sample one edge after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sample clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| sampleIn | input | WIDTH | One sample per clock edge |
| syncIn | input | 1 | Synchronous phase realignment request |
| priPort | output | WIDTH | Newer sample of each pair |
| auxPort | output | WIDTH | Older sample of each pair |
| rdyOut | output | 1 | Half-rate data-ready flag; its rising transition marks a port update |
| rstOut | output | 1 | Delayed copy of syncIn for downstream stages |

## Verification
The realignment edge, where `rstOut` falls, can coincide with an edge on which the toggle flag would otherwise rise and load the ports. This is the swallow case. It can also coincide with a plain falling toggle, which is the aligned case. The bench sends many `syncIn` pulses of random length 1 to 4 with random gaps, some shorter than the pulse delay so that pulses overlap in flight. This makes both coincidences occur. Every edge is judged against a reference model built from R2, R5 and R8, and the run also checks that at least one swallowed and at least one aligned realignment occurred.

// File: rtl/demux_pkg.sv
package demux_pkg;
  // strobe set from control to datapath, one per sample-clock edge
  typedef struct packed {
    logic load;     // ports take a new pair on this edge
    logic realign;  // phase of the half-rate flag is forced on this edge
  } demuxStrobe_t;
endpackage

// File: rtl/demux_ctrl.sv
module demux_ctrl
  import demux_pkg::*;
#(
  parameter int PRI_LAT = 7
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         syncIn,
  output logic         rdyOut,
  output logic         rstOut,
  output demuxStrobe_t strobe
);
  localparam int RST_LAT = PRI_LAT - 1;

  logic [RST_LAT:0] rstPipe;
  logic             rdyQ;
  logic             rdyNext;

  // stage i holds syncIn from i edges back
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstPipe <= '0;
    else       rstPipe <= {rstPipe[RST_LAT-1:0], syncIn};
  end

  assign rstOut = rstPipe[RST_LAT];

  always_comb begin
    strobe.realign = rstPipe[RST_LAT] & ~rstPipe[RST_LAT-1];
    rdyNext        = strobe.realign ? 1'b0 : ~rdyQ;
    strobe.load    = rdyNext & ~rdyQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdyQ <= 1'b0;
    else       rdyQ <= rdyNext;
  end

  assign rdyOut = rdyQ;

  // R2
  rdy_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rstOut |=> (rdyOut != $past(rdyOut)));

  // R7
  rdy_during_rst_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rstOut && $past(rstOut)) |-> (rdyOut != $past(rdyOut)));

  // R8
  rdy_realign_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rstOut) |-> !rdyOut);
endmodule

// File: rtl/demux_datapath.sv
module demux_datapath
  import demux_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter int PRI_LAT = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] sampleIn,
  input  demuxStrobe_t     strobe,
  output logic [WIDTH-1:0] priPort,
  output logic [WIDTH-1:0] auxPort
);
  localparam int DEPTH = PRI_LAT + 1;

  logic [WIDTH-1:0] pipe [DEPTH];
  logic [WIDTH-1:0] priQ;
  logic [WIDTH-1:0] auxQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe[0] <= '0;
    else       pipe[0] <= sampleIn;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe[i] <= '0;
      else       pipe[i] <= pipe[i-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      priQ <= '0;
      auxQ <= '0;
    end else if (strobe.load) begin
      priQ <= pipe[PRI_LAT-1];
      auxQ <= pipe[PRI_LAT];
    end
  end

  assign priPort = priQ;
  assign auxPort = auxQ;

  // R3
  port_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> ($stable(priQ) && $stable(auxQ)));

  // R5
  pri_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (priQ == $past(pipe[PRI_LAT-2], 2)));

  // R4
  aux_older_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (auxQ == $past(pipe[PRI_LAT-1], 2)));
endmodule

// File: rtl/sample_demux_1to2.sv
module sample_demux_1to2
  import demux_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter int PRI_LAT = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] sampleIn,
  input  logic             syncIn,
  output logic [WIDTH-1:0] priPort,
  output logic [WIDTH-1:0] auxPort,
  output logic             rdyOut,
  output logic             rstOut
);
  demuxStrobe_t strobe;

  demux_ctrl #(.PRI_LAT(PRI_LAT)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .syncIn (syncIn),
    .rdyOut (rdyOut),
    .rstOut (rstOut),
    .strobe (strobe)
  );

  demux_datapath #(.WIDTH(WIDTH), .PRI_LAT(PRI_LAT)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .sampleIn (sampleIn),
    .strobe   (strobe),
    .priPort  (priPort),
    .auxPort  (auxPort)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |-> (!rdyOut && !rstOut && priPort == '0 && auxPort == '0));
endmodule

// File: tb/sample_demux_1to2_tb.sv
module sample_demux_1to2_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_CYCLES = 3000;
  localparam int HIST       = 4096;

  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] sampleIn;
  logic       syncIn;
  logic [7:0] priPort, auxPort;
  logic       rdyOut, rstOut;

  int checks = 0;
  int errors = 0;

  logic [7:0] smpHist [HIST];
  logic       synHist [HIST];
  int         edgeN = 0;
  bit         running = 1'b0;

  // reference state
  logic       expRdy = 1'b0, prevRdy = 1'b0, expRst = 1'b0, prevRst = 1'b0;
  logic [7:0] expPri = '0, expAux = '0;
  bit         justFell = 1'b0, didLoad = 1'b0, firstAfter = 1'b0, pendFirst = 1'b0;
  int         swallows = 0, aligned = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sample_demux_1to2 dut_i (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .syncIn(syncIn),
    .priPort(priPort), .auxPort(auxPort), .rdyOut(rdyOut), .rstOut(rstOut)
  );

  function automatic logic [7:0] smpAt(int idx);
    return (idx < 0) ? 8'h00 : smpHist[idx];
  endfunction

  function automatic logic synAt(int idx);
    return (idx < 0) ? 1'b0 : synHist[idx];
  endfunction

  // model: R6 delay, R2/R7/R8 flag, R5/R4 port contents
  always @(posedge clk) begin
    if (running) begin
      logic newRst, newRdy;
      newRst  = synAt(edgeN - 6);
      justFell = expRst && !newRst;
      newRdy  = justFell ? 1'b0 : ~expRdy;
      if (justFell) begin
        if (expRdy) aligned++;
        else        swallows++;
      end
      didLoad    = newRdy && !expRdy;
      firstAfter = didLoad && pendFirst;
      if (didLoad) begin
        expPri    = smpAt(edgeN - 7);
        expAux    = smpAt(edgeN - 8);
        pendFirst = 1'b0;
      end
      if (justFell) pendFirst = 1'b1;
      prevRst = expRst;
      prevRdy = expRdy;
      expRst  = newRst;
      expRdy  = newRdy;
      edgeN++;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (edge %0d)", tag, act, exp, edgeN);
    end
  endtask

  task automatic compareAll();
    string rdyTag;
    rdyTag = justFell ? "R8" : (prevRst && expRst) ? "R7" : "R2";
    check(rdyOut == expRdy, rdyTag, rdyOut, expRdy);
    check(rstOut == expRst, "R6", rstOut, expRst);
    if (firstAfter) begin
      check(priPort == expPri, "R9 pri", priPort, expPri);
      check(auxPort == expAux, "R9 aux", auxPort, expAux);
    end else if (didLoad) begin
      check(priPort == expPri, "R5", priPort, expPri);
      check(auxPort == expAux, "R4", auxPort, expAux);
    end else begin
      check(priPort == expPri && auxPort == expAux, "R3", {priPort, auxPort}, {expPri, expAux});
    end
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    int gapLeft = 20;
    int lenLeft = 0;
    void'($urandom(32'h5eed_0042));
    rstN = 1'b0; sampleIn = 8'h00; syncIn = 1'b0;
    repeat (3) @(negedge clk);
    sampleIn = 8'hA5; syncIn = 1'b1;
    @(negedge clk);
    // R1 outputs quiet under reset even with active inputs
    check(priPort == 8'h00, "R1 pri", priPort, 0);
    check(auxPort == 8'h00, "R1 aux", auxPort, 0);
    check(rdyOut == 1'b0, "R1 rdy", rdyOut, 0);
    check(rstOut == 1'b0, "R1 rst", rstOut, 0);
    syncIn = 1'b0;
    rstN = 1'b1;
    running = 1'b1;
    for (int c = 0; c < RUN_CYCLES; c++) begin
      logic [7:0] s;
      logic       y;
      if (c == 0) lenLeft = 0;
      if (c < 300)      s = 8'(c);
      else if (c < 400) s = c[0] ? 8'hFF : 8'h00;
      else              s = 8'($urandom);
      if (lenLeft > 0) begin
        y = 1'b1; lenLeft--;
      end else if (gapLeft > 0) begin
        y = 1'b0; gapLeft--;
      end else begin
        lenLeft = (c < 40) ? 2 : 1 + int'($urandom % 4);
        gapLeft = 1 + int'($urandom % 24);
        y = 1'b1; lenLeft--;
      end
      sampleIn = s;
      syncIn   = y;
      smpHist[edgeN] = s;
      synHist[edgeN] = y;
      @(negedge clk);
      compareAll();
    end
    // R8 both realignment cases must have been reached
    check(swallows > 0, "R8 swallow seen", swallows, 1);
    check(aligned > 0, "R8 aligned seen", aligned, 1);
    finishRun();
  end
endmodule